// File: doc/BRIEF.md
# Low-Power PWM Timer

A single-channel pulse-width modulation timer. A small synchronous register bus lets software set it up. A power-of-two prescaler makes a tick enable, and a 16-bit up-counter advances on each tick. The counter runs from zero up to the auto-reload value and then wraps. The output is active while the counter is above the compare value. A polarity bit decides whether active means high or low.

Software uses the block in this order:
1. With the timer disabled, write the prescaler and polarity.
2. Set the enable bit.
3. Write auto-reload and compare. Each accepted write raises its own acknowledge flag, and software clears the flags through a write-one-to-clear register.
4. Set the start bit to begin continuous counting.

New auto-reload and compare values reach the running counter only at a wrap, so a period is never cut short.

Top module: `lp_pwm_timer`

## Requirements
- R1: After reset, every readable register reads 0 and `pwm_out` is 0.
- R2: The configuration register (offset 0x04) holds polarity in bit 0 and the prescaler exponent in bits 6:4. A write to it changes these fields only while the enable bit is 0. A write while enabled leaves the register unchanged.
- R3: Auto-reload (offset 0x08) and compare (offset 0x0C) are 16 bits wide. A write to either is accepted only while the enable bit is 1. A write while disabled leaves the stored value unchanged.
- R4: Status (offset 0x10) shows a compare-acknowledge flag in bit 0 and an auto-reload-acknowledge flag in bit 1. A flag is still 0 in the bus cycle after an accepted write to its register, and reads 1 from the cycle after that.
- R5: Writing 1 to bit 0 or bit 1 of the clear register (offset 0x14) clears the matching status flag on that clock edge. Writing 0 to a bit leaves its flag alone.
- R6: Control (offset 0x00) reads enable in bit 0 and running in bit 1. The start bit (bit 1) sets running only if enable was already 1 before the write and bit 0 of the write is also 1. Writing 0 clears both bits and stops counting.
- R7: While the timer is not running, the counter stays at 0. `pwm_out` then rests at its inactive level, which is the polarity bit.
- R8: Each period lasts auto-reload + 1 ticks. The output is active for auto-reload − compare ticks of each period and never active when compare ≥ auto-reload. Active means high with polarity 0 and low with polarity 1.
- R9: One tick lasts 2^N clock cycles, where N is the prescaler exponent (0 to 7).
- R10: While running, new auto-reload and compare values reach the counter logic only at a counter wrap. While not running, the counter logic follows the written values at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pwm_out | output | 1 | PWM waveform |

## Verification
The hardest state to reach is a change to compare or auto-reload while the counter is part-way through a period. This state has no visible phase at the ports. The bench reaches it by writing new values while the timer runs and then waiting more than two full periods. It then counts active cycles over a whole number of periods. That count does not depend on the phase, so it shows whether the new values took effect. The assertion on the active copies checks that they changed only at a wrap. The acknowledge timing is read back in the first and second bus cycles after each write.

// File: rtl/lpt_pkg.sv
// Shared constants and types for the low-power PWM timer.
// Assumes a byte-addressed bus with word-aligned registers.
package lpt_pkg;
    localparam int unsigned PSC_W = 3;

    // Register byte offsets
    localparam int unsigned OFS_CTRL = 'h00;
    localparam int unsigned OFS_CFG  = 'h04;
    localparam int unsigned OFS_ARR  = 'h08;
    localparam int unsigned OFS_CMP  = 'h0C;
    localparam int unsigned OFS_STAT = 'h10;
    localparam int unsigned OFS_CLR  = 'h14;

    // Field positions shared by the register block and its users
    localparam int unsigned BIT_EN    = 0;
    localparam int unsigned BIT_START = 1;
    localparam int unsigned BIT_POL   = 0;
    localparam int unsigned PSC_LSB   = 4;
    localparam int unsigned BIT_CMPOK = 0;
    localparam int unsigned BIT_ARROK = 1;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic             pol;
    } cfg_t;
endpackage

// File: rtl/lpt_regs.sv
// Register file and write-acknowledge logic.
// Assumes single-cycle bus writes. Reads are combinational from bus_addr.
// Configuration is locked while enabled, and auto-reload and compare are
// locked while disabled.
module lpt_regs #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              en,
    output logic              running,
    output lpt_pkg::cfg_t     cfg,
    output logic [CNT_W-1:0]  arr_pre,
    output logic [CNT_W-1:0]  cmp_pre,
    output logic              arr_acc,
    output logic              cmp_acc,
    output logic              arr_ok,
    output logic              cmp_ok
);
    import lpt_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_ARR  = ADDR_W'(OFS_ARR);
    localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(OFS_CMP);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

    logic wr;
    logic wr_ctrl, wr_cfg, wr_clr;
    logic arr_pend, cmp_pend;
    logic unused_wdata;

    assign wr      = bus_sel && bus_wr;
    assign wr_ctrl = wr && (bus_addr == A_CTRL);
    assign wr_cfg  = wr && (bus_addr == A_CFG);
    assign wr_clr  = wr && (bus_addr == A_CLR);
    assign arr_acc = wr && (bus_addr == A_ARR) && en;
    assign cmp_acc = wr && (bus_addr == A_CMP) && en;
    assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

    // Control, configuration and preload registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            running <= 1'b0;
            cfg     <= '0;
            arr_pre <= '0;
            cmp_pre <= '0;
        end else begin
            if (wr_ctrl) begin
                en      <= bus_wdata[BIT_EN];
                running <= bus_wdata[BIT_EN] && bus_wdata[BIT_START] && en;
            end
            if (wr_cfg && !en) begin
                cfg.pol <= bus_wdata[BIT_POL];
                cfg.psc <= bus_wdata[PSC_LSB +: PSC_W];
            end
            if (arr_acc) arr_pre <= bus_wdata[CNT_W-1:0];
            if (cmp_acc) cmp_pre <= bus_wdata[CNT_W-1:0];
        end
    end

    // Acknowledge flags: one pending stage, then the flag; a set wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_pend <= 1'b0;
            cmp_pend <= 1'b0;
            arr_ok   <= 1'b0;
            cmp_ok   <= 1'b0;
        end else begin
            arr_pend <= arr_acc;
            cmp_pend <= cmp_acc;
            arr_ok   <= arr_pend || (arr_ok && !(wr_clr && bus_wdata[BIT_ARROK]));
            cmp_ok   <= cmp_pend || (cmp_ok && !(wr_clr && bus_wdata[BIT_CMPOK]));
        end
    end

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[BIT_EN]    = en;
                bus_rdata[BIT_START] = running;
            end
            A_CFG: begin
                bus_rdata[BIT_POL]             = cfg.pol;
                bus_rdata[PSC_LSB +: PSC_W]    = cfg.psc;
            end
            A_ARR:  bus_rdata[CNT_W-1:0] = arr_pre;
            A_CMP:  bus_rdata[CNT_W-1:0] = cmp_pre;
            A_STAT: begin
                bus_rdata[BIT_CMPOK] = cmp_ok;
                bus_rdata[BIT_ARROK] = arr_ok;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lpt_prescaler.sv
// Power-of-two tick generator.
// Assumes psc changes only while run is low; the divider restarts from zero
// whenever run is low.
module lpt_prescaler #(
    parameter int unsigned PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    localparam int unsigned DIV_W = (1 << PSC_W) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_mask;

    // Mask of the low psc bits of the divider
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            div_mask[i] = (i < int'(psc));
        end
    end

    assign tick = run && ((div_cnt & div_mask) == div_mask);

    // Free-running divider while running
    always_ff @(posedge clk) begin
        if (!rst_n || !run) div_cnt <= '0;
        else                div_cnt <= div_cnt + 1'b1;
    end
endmodule

// File: rtl/lpt_counter.sv
// Period counter, active copies of auto-reload and compare, and the output.
// Assumes tick is only high while run is high. The active copies follow the
// preloads while stopped and reload only at a wrap while running.
module lpt_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             pol,
    input  logic [CNT_W-1:0] arr_pre,
    input  logic [CNT_W-1:0] cmp_pre,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] arr_act,
    output logic [CNT_W-1:0] cmp_act,
    output logic             load,
    output logic             pwm_out
);
    logic wrap;

    assign wrap    = tick && (cnt == arr_act);
    assign load    = !run || wrap;
    assign pwm_out = pol ^ (run && (cnt > cmp_act));

    // Counter advance and wrap
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (wrap)      cnt <= '0;
        else if (tick)      cnt <= cnt + 1'b1;
    end

    // Active-copy reload from the preloads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_act <= '0;
            cmp_act <= '0;
        end else if (load) begin
            arr_act <= arr_pre;
            cmp_act <= cmp_pre;
        end
    end
endmodule

// File: rtl/lp_pwm_timer.sv
// Low-power PWM timer top: the register block, the prescaler and the period
// counter. Assumes a single clock domain and synchronous active-low reset.
module lp_pwm_timer #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);
    import lpt_pkg::*;

    logic             ctrl_en, running, tick, load;
    logic             arr_acc, cmp_acc, arr_ok, cmp_ok;
    cfg_t             cfg;
    logic [CNT_W-1:0] arr_pre, cmp_pre, arr_act, cmp_act, cnt;

    lpt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .en(ctrl_en), .running(running), .cfg(cfg),
        .arr_pre(arr_pre), .cmp_pre(cmp_pre),
        .arr_acc(arr_acc), .cmp_acc(cmp_acc), .arr_ok(arr_ok), .cmp_ok(cmp_ok)
    );

    lpt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(running), .psc(cfg.psc), .tick(tick)
    );

    lpt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(running), .tick(tick), .pol(cfg.pol),
        .arr_pre(arr_pre), .cmp_pre(cmp_pre), .cnt(cnt),
        .arr_act(arr_act), .cmp_act(cmp_act), .load(load), .pwm_out(pwm_out)
    );
endmodule

// File: rtl/lpt_checker.sv
// Property checker for lp_pwm_timer, attached by bind. Observes only.
module lpt_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             running,
    input logic [3:0]       cfg_bits,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] arr_act,
    input logic [CNT_W-1:0] cmp_act,
    input logic             load,
    input logic             arr_acc,
    input logic             cmp_acc,
    input logic             arr_ok,
    input logic             cmp_ok,
    input logic             pol,
    input logic             pwm_out
);
    // R2: configuration cannot change across an edge where enable was set
    a_r2_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en) |-> $stable(cfg_bits));

    // R4: an acknowledge flag rises exactly two edges after its accepted write
    a_r4_arr_ok_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_ok) |-> $past(arr_acc, 2));
    a_r4_cmp_ok_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_ok) |-> $past(cmp_acc, 2));

    // R7: counter held at zero after a stopped cycle
    a_r7_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(running) |-> (cnt == '0));

    // R7: disabled output rests at the polarity level
    a_r7_out_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (pwm_out == pol));

    // R8: counter never passes the active auto-reload value
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt <= arr_act));

    // R10: active copies change only after a load slot
    a_r10_arr_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_act != $past(arr_act)) |-> $past(load));
    a_r10_cmp_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_act != $past(cmp_act)) |-> $past(load));
endmodule

bind lp_pwm_timer lpt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .running(running),
    .cfg_bits(cfg), .cnt(cnt), .arr_act(arr_act), .cmp_act(cmp_act),
    .load(load), .arr_acc(arr_acc), .cmp_acc(cmp_acc),
    .arr_ok(arr_ok), .cmp_ok(cmp_ok), .pol(cfg.pol), .pwm_out(pwm_out)
);

// File: tb/lp_pwm_timer_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: tasks queue expected values, observations queue actual
// values, and a monitor process pairs and compares them.
module lp_pwm_timer_bench;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam int A_CTRL = 'h00, A_CFG = 'h04, A_ARR = 'h08;
    localparam int A_CMP = 'h0C, A_STAT = 'h10, A_CLR = 'h14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              pwm_out;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string exp_tag_q[$];
    int    exp_q[$];
    int    act_q[$];

    always #2.5 clk = ~clk;

    lp_pwm_timer u_lp_pwm_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    // Monitor: pair expected and observed items in order
    task automatic compare_pending();
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            string t;
            int e;
            int a;
            t = exp_tag_q.pop_front();
            e = exp_q.pop_front();
            a = act_q.pop_front();
            checks++;
            if (a != e) begin
                errors++;
                $display("FAIL %s: actual=%0d expected=%0d", t, a, e);
            end
        end
    endtask

    always @(negedge clk) compare_pending();

    task automatic expect_item(string tag, int v);
        exp_tag_q.push_back(tag);
        exp_q.push_back(v);
    endtask

    task automatic bus_write(int addr, int data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = ADDR_W'(addr); bus_wdata = DATA_W'(data);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic check_reg(string tag, int addr, int exp);
        expect_item(tag, exp);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(addr);
        #1;
        act_q.push_back(int'(bus_rdata));
        bus_sel = 1'b0;
    endtask

    task automatic measure(string tag, int n, int exp_high);
        int high = 0;
        expect_item(tag, exp_high);
        repeat (n) begin
            @(negedge clk);
            #1;
            high += int'(pwm_out);
        end
        act_q.push_back(high);
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        compare_pending();
        if (exp_q.size() != act_q.size()) begin
            errors++;
            checks++;
            $display("FAIL scoreboard: actual=%0d expected=%0d", act_q.size(), exp_q.size());
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        wait_cycles(4);
        rst_n = 1'b1;
        wait_cycles(1);
        // R1 reset state
        check_reg("R1 ctrl", A_CTRL, 0);
        check_reg("R1 cfg", A_CFG, 0);
        check_reg("R1 arr", A_ARR, 0);
        check_reg("R1 cmp", A_CMP, 0);
        check_reg("R1 stat", A_STAT, 0);
        measure("R1 out", 2, 0);
        // R3 auto-reload write while disabled is dropped
        bus_write(A_ARR, 5);
        check_reg("R3 arr disabled", A_ARR, 0);
        wait_cycles(2);
        check_reg("R3 no ack", A_STAT, 0);
        // R2 configuration writable while disabled
        bus_write(A_CFG, 'h31);
        check_reg("R2 cfg write", A_CFG, 'h31);
        bus_write(A_CFG, 'h00);
        check_reg("R2 cfg clear", A_CFG, 0);
        // R6 start ignored when enable was 0 before
        bus_write(A_CTRL, 3);
        check_reg("R6 start needs enable", A_CTRL, 1);
        // R3 and R4 auto-reload acknowledge timing
        bus_write(A_ARR, 9);
        check_reg("R4 arr ok not yet", A_STAT, 0);
        wait_cycles(1);
        check_reg("R4 arr ok set", A_STAT, 2);
        check_reg("R3 arr stored", A_ARR, 9);
        bus_write(A_CMP, 3);
        check_reg("R4 cmp ok not yet", A_STAT, 2);
        wait_cycles(1);
        check_reg("R4 cmp ok set", A_STAT, 3);
        // R5 clear only the auto-reload flag
        bus_write(A_CLR, 2);
        check_reg("R5 clear arr ok", A_STAT, 1);
        bus_write(A_CLR, 0);
        check_reg("R5 clear zero", A_STAT, 1);
        // R2 configuration locked while enabled
        bus_write(A_CFG, 'h01);
        check_reg("R2 cfg locked", A_CFG, 0);
        // R7 enabled but not started: idle
        measure("R7 idle before start", 20, 0);
        // R6 start, R8 duty with ARR=9 CMP=3
        bus_write(A_CTRL, 3);
        check_reg("R6 running", A_CTRL, 3);
        wait_cycles(12);
        measure("R8 duty 6 of 10", 10, 6);
        // R8 compare zero gives ARR active ticks
        bus_write(A_CMP, 0);
        wait_cycles(25);
        measure("R8 cmp zero", 10, 9);
        // R8 compare equal to and above auto-reload
        bus_write(A_CMP, 9);
        wait_cycles(25);
        measure("R8 cmp equal arr", 10, 0);
        bus_write(A_CMP, 12);
        wait_cycles(25);
        measure("R8 cmp above arr", 10, 0);
        // R10 new values applied while running
        bus_write(A_ARR, 19);
        bus_write(A_CMP, 9);
        wait_cycles(45);
        measure("R10 new period", 20, 10);
        // R6 stop; R7 idle output; R3 write while disabled dropped
        bus_write(A_CTRL, 0);
        check_reg("R6 stopped", A_CTRL, 0);
        measure("R7 stopped out", 5, 0);
        bus_write(A_ARR, 7);
        check_reg("R3 arr kept", A_ARR, 19);
        // R7 inactive high with polarity 1; R9 prescaler 2
        bus_write(A_CFG, 'h11);
        check_reg("R2 cfg pol psc", A_CFG, 'h11);
        measure("R7 inactive high", 4, 4);
        bus_write(A_CTRL, 1);
        bus_write(A_ARR, 9);
        bus_write(A_CMP, 3);
        bus_write(A_CTRL, 3);
        wait_cycles(45);
        measure("R9 R8 psc2 inverted", 20, 8);
        // R9 largest prescaler
        bus_write(A_CTRL, 0);
        bus_write(A_CFG, 'h70);
        bus_write(A_CTRL, 1);
        bus_write(A_ARR, 1);
        bus_write(A_CMP, 0);
        bus_write(A_CTRL, 3);
        wait_cycles(300);
        measure("R9 psc128", 256, 128);
        wait_cycles(2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule